// File: doc/BRIEF.md
# Memory-Backed Convolutional Deinterleaver

This block undoes an (I, J) convolutional interleave on a byte stream. Branch k of the deinterleaver must delay its symbols by (I-1-k)·J visits of the commutator. Here every branch delay line lives in one shared memory of J·I·(I-1)/2 + J entries, not in its own FIFO. Two pointers walk that memory with shrinking strides. At the end of each commutator cycle, the base of each pointer moves back by one location. Every address wraps modulo the active bound.

The depth I and the per-branch step J are run-time inputs. They are captured from the first symbol that carries the frame-start strobe. The memory is sized by a parameter that must cover the largest mode in use. A frame start that falls on the top branch, with the same mode, leaves the stream running. A frame start that arrives mid-cycle, or with a new mode, restarts the commutator and the pointers. Each accepted symbol produces one output exactly one cycle later. A fill flag marks the point from which the outputs are the deinterleaved stream.

Top module: `cdi_deinterleaver`

## Requirements
- R1: While rst_ni is low and right after its release, valid_o and filled_o are 0.
- R2: Until the first symbol presented with frame_start_i high, symbols with valid_i high are dropped and valid_o stays 0.
- R3: Every accepted symbol gives valid_o high exactly one clock later. A cycle without an accepted symbol gives valid_o low one clock later.
- R4: Count accepted symbols from t=0 at the restarting frame start. The input symbol at t on branch t mod I is taken to be source symbol t - (t mod I)·J·I. For t >= J·I·(I-1), the output for index t equals source symbol t - J·I·(I-1).
- R5: A symbol on the last branch, I-1, bypasses the memory. It appears unchanged on data_o one cycle later, including during the fill period.
- R6: Set F = J·I·(I-1). filled_o is low with the outputs for indices below F. It is high with the output for index F and after it, until the next restart.
- R7: Cycles with valid_i low do not move the commutator or the pointers.
- R8: A frame start on a top-branch symbol, with unchanged depth_i and step_i, does not disturb the output stream.
- R9: A frame start on a symbol that is not on the top branch, or with a changed depth_i or step_i, restarts the block. That symbol becomes index 0 under the new mode, and filled_o drops.
- R10: Read and write addresses stay below the bound J·I·(I-1)/2 + J. The read and write of one symbol never target the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input symbol present |
| data_i | input | DW | Input symbol |
| frame_start_i | input | 1 | Marks the symbol as the first of a frame (top branch) |
| depth_i | input | I_W | Interleave depth I, 2 or more |
| step_i | input | J_W | Branch step J, 1 or more |
| valid_o | output | 1 | Output symbol present |
| data_o | output | DW | Output symbol |
| filled_o | output | 1 | Outputs are deinterleaved data |

## Verification
The checker watches several properties on every cycle:
- the one-cycle latency and the quiet output on idle cycles;
- the unchanged pass-through of last-branch symbols;
- the stickiness of filled_o while no symbol arrives;
- the address range, and the absence of a read/write collision on the same location.

Whether the shrinking strides and the shifting base addresses actually restore the source order can only be shown by the bench. It feeds an arithmetically modelled interleaved stream through several modes, with idle gaps, aligned and misaligned frame starts, and mode changes. It compares every post-fill output against the source index it must carry.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  // entries held for one mode: J*I*(I-1)/2 + J
  function automatic int unsigned cdi_bound(input int unsigned i, input int unsigned j);
    return (j * i * (i - 1)) / 2 + j;
  endfunction

  // symbols until outputs are valid: J*I*(I-1)
  function automatic int unsigned cdi_fill(input int unsigned i, input int unsigned j);
    return j * i * (i - 1);
  endfunction
endpackage

// File: rtl/cdi_mode_calc.sv
module cdi_mode_calc #(
  parameter int I_W = 8,
  parameter int J_W = 5,
  parameter int AW  = 11
) (
  input  logic [I_W-1:0] depth_i,
  input  logic [J_W-1:0] step_i,
  output logic [AW:0]    bound_o,
  output logic [AW:0]    stride0_o,
  output logic [AW+1:0]  fill_o
);
  import cdi_pkg::*;

  int unsigned i_u, j_u;

  always_comb begin
    i_u       = int'(depth_i);
    j_u       = int'(step_i);
    bound_o   = (AW+1)'(cdi_bound(i_u, j_u));
    stride0_o = (AW+1)'((i_u - 1) * j_u);
    fill_o    = (AW+2)'(cdi_fill(i_u, j_u));
  end
endmodule

// File: rtl/cdi_addr_gen.sv
module cdi_addr_gen #(
  parameter int I_W = 8,
  parameter int J_W = 5,
  parameter int AW  = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  logic           restart_i,
  input  logic [I_W-1:0] depth_i,
  input  logic [J_W-1:0] step_i,
  input  logic [AW:0]    bound_i,
  input  logic [AW:0]    stride0_i,
  output logic [AW-1:0]  waddr_o,
  output logic [AW-1:0]  raddr_o,
  output logic           bypass_o,
  output logic           branch_zero_o
);
  logic [I_W-1:0] branch_q, branch_d, cur_branch;
  logic [AW-1:0]  w_ptr_q, w_ptr_d, r_ptr_q, r_ptr_d;
  logic [AW-1:0]  w_ini_q, w_ini_d, r_ini_q, r_ini_d;
  logic [AW-1:0]  cur_w, cur_r, cur_wini, cur_rini;
  logic [AW:0]    stride_q, stride_d, cur_stride, rd_stride, step_ext;

  function automatic logic [AW-1:0] add_mod(input logic [AW-1:0] a, input logic [AW:0] b,
                                            input logic [AW:0] m);
    logic [AW:0] s;
    s = {1'b0, a} + b;
    if (s >= m) s = s - m;
    return s[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] dec_mod(input logic [AW-1:0] a, input logic [AW:0] m);
    logic [AW:0] s;
    s = (a == '0) ? (m - 1'b1) : ({1'b0, a} - 1'b1);
    return s[AW-1:0];
  endfunction

  always_comb begin
    step_ext   = {{(AW+1-J_W){1'b0}}, step_i};
    cur_branch = restart_i ? '0 : branch_q;
    cur_w      = restart_i ? '0 : w_ptr_q;
    cur_wini   = restart_i ? '0 : w_ini_q;
    cur_r      = restart_i ? stride0_i[AW-1:0] : r_ptr_q;
    cur_rini   = restart_i ? stride0_i[AW-1:0] : r_ini_q;
    cur_stride = restart_i ? stride0_i : stride_q;
    rd_stride  = cur_stride - step_ext;
    bypass_o   = (cur_branch == depth_i - 1'b1);

    branch_d = branch_q;
    w_ptr_d  = w_ptr_q;
    r_ptr_d  = r_ptr_q;
    w_ini_d  = w_ini_q;
    r_ini_d  = r_ini_q;
    stride_d = stride_q;
    if (accept_i) begin
      if (bypass_o) begin
        // cycle end: bases move back one location
        w_ini_d  = dec_mod(cur_wini, bound_i);
        r_ini_d  = dec_mod(cur_rini, bound_i);
        w_ptr_d  = w_ini_d;
        r_ptr_d  = r_ini_d;
        stride_d = stride0_i;
        branch_d = '0;
      end else begin
        w_ini_d  = cur_wini;
        r_ini_d  = cur_rini;
        w_ptr_d  = add_mod(cur_w, cur_stride, bound_i);
        r_ptr_d  = add_mod(cur_r, rd_stride, bound_i);
        stride_d = rd_stride;
        branch_d = cur_branch + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      branch_q <= '0;
      w_ptr_q  <= '0;
      r_ptr_q  <= '0;
      w_ini_q  <= '0;
      r_ini_q  <= '0;
      stride_q <= '0;
    end else begin
      branch_q <= branch_d;
      w_ptr_q  <= w_ptr_d;
      r_ptr_q  <= r_ptr_d;
      w_ini_q  <= w_ini_d;
      r_ini_q  <= r_ini_d;
      stride_q <= stride_d;
    end
  end

  assign waddr_o       = cur_w;
  assign raddr_o       = cur_r;
  assign branch_zero_o = (branch_q == '0);
endmodule

// File: rtl/cdi_mem.sv
module cdi_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // read returns the old word; write lands at the same edge
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      rdata_o         <= mem_q[raddr_i];
      mem_q[waddr_i]  <= wdata_i;
    end
  end
endmodule

// File: rtl/cdi_deinterleaver.sv
module cdi_deinterleaver #(
  parameter int DW        = 8,
  parameter int I_W       = 8,
  parameter int J_W       = 5,
  parameter int MEM_DEPTH = 2048
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           valid_i,
  input  logic [DW-1:0]  data_i,
  input  logic           frame_start_i,
  input  logic [I_W-1:0] depth_i,
  input  logic [J_W-1:0] step_i,
  output logic           valid_o,
  output logic [DW-1:0]  data_o,
  output logic           filled_o
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int FW = AW + 2;

  logic [I_W-1:0] depth_q, depth_eff;
  logic [J_W-1:0] step_q, step_eff;
  logic           primed_q, restart, accept, bypass, branch_zero;
  logic [AW:0]    bound, stride0;
  logic [FW-1:0]  fill, cnt_q, t_eff;
  logic [AW-1:0]  waddr, raddr;
  logic [DW-1:0]  rdata, byp_data_q;
  logic           byp_q, valid_q, filled_q;

  assign restart = valid_i && frame_start_i &&
                   (!primed_q || depth_i != depth_q || step_i != step_q || !branch_zero);
  assign accept    = valid_i && (primed_q || restart);
  assign depth_eff = restart ? depth_i : depth_q;
  assign step_eff  = restart ? step_i  : step_q;

  cdi_mode_calc #(.I_W(I_W), .J_W(J_W), .AW(AW)) u_mode (
    .depth_i  (depth_eff),
    .step_i   (step_eff),
    .bound_o  (bound),
    .stride0_o(stride0),
    .fill_o   (fill)
  );

  cdi_addr_gen #(.I_W(I_W), .J_W(J_W), .AW(AW)) u_addr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .restart_i    (restart),
    .depth_i      (depth_eff),
    .step_i       (step_eff),
    .bound_i      (bound),
    .stride0_i    (stride0),
    .waddr_o      (waddr),
    .raddr_o      (raddr),
    .bypass_o     (bypass),
    .branch_zero_o(branch_zero)
  );

  cdi_mem #(.DW(DW), .DEPTH(MEM_DEPTH), .AW(AW)) u_mem (
    .clk_i  (clk_i),
    .en_i   (accept && !bypass),
    .waddr_i(waddr),
    .wdata_i(data_i),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  assign t_eff = restart ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q    <= '0;
      step_q     <= '0;
      primed_q   <= 1'b0;
      cnt_q      <= '0;
      filled_q   <= 1'b0;
      valid_q    <= 1'b0;
      byp_q      <= 1'b0;
      byp_data_q <= '0;
    end else begin
      valid_q <= accept;
      if (restart) begin
        depth_q  <= depth_i;
        step_q   <= step_i;
        primed_q <= 1'b1;
      end
      if (accept) begin
        byp_q      <= bypass;
        byp_data_q <= data_i;
        filled_q   <= (t_eff >= fill);
        cnt_q      <= (t_eff >= fill) ? t_eff : t_eff + 1'b1;
      end
    end
  end

  assign valid_o  = valid_q;
  assign filled_o = filled_q;
  assign data_o   = byp_q ? byp_data_q : rdata;
endmodule

// File: rtl/cdi_checker.sv
module cdi_checker #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          accept,
  input logic          bypass,
  input logic [AW-1:0] waddr,
  input logic [AW-1:0] raddr,
  input logic [AW:0]   bound,
  input logic [DW-1:0] data_i,
  input logic          valid_o,
  input logic [DW-1:0] data_o,
  input logic          filled_o
);
  AST_ACCEPT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> valid_o); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !valid_o); // R3
  AST_BYPASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bypass) |=> (data_o == $past(data_i))); // R5
  AST_FILLED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filled_o && !accept) |=> filled_o); // R6
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !bypass) |-> ({1'b0, waddr} < bound && {1'b0, raddr} < bound)); // R10
  AST_NO_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !bypass) |-> (waddr != raddr)); // R10
endmodule

bind cdi_deinterleaver cdi_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .accept  (accept),
  .bypass  (bypass),
  .waddr   (waddr),
  .raddr   (raddr),
  .bound   (bound),
  .data_i  (data_i),
  .valid_o (valid_o),
  .data_o  (data_o),
  .filled_o(filled_o)
);

// File: tb/tb_cdi_deinterleaver.sv
module tb_cdi_deinterleaver;
  localparam int CLK_P = 10;
  localparam int DW = 8, I_W = 8, J_W = 5, MEM_DEPTH = 2048;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           valid_i = 1'b0;
  logic [DW-1:0]  data_i = '0;
  logic           frame_start_i = 1'b0;
  logic [I_W-1:0] depth_i = '0;
  logic [J_W-1:0] step_i = '0;
  logic           valid_o, filled_o;
  logic [DW-1:0]  data_o;

  int errors = 0, checks = 0;
  bit p_acc = 0;
  int p_t = 0, p_i = 2, p_j = 1;
  logic [DW-1:0] p_din = '0;
  string p_tag = "";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cdi_deinterleaver #(.DW(DW), .I_W(I_W), .J_W(J_W), .MEM_DEPTH(MEM_DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .frame_start_i(frame_start_i), .depth_i(depth_i), .step_i(step_i),
    .valid_o(valid_o), .data_o(data_o), .filled_o(filled_o)
  );

  function automatic logic [7:0] src_sym(input int s);
    return 8'((s * 73) + ((s >>> 8) * 11) + 5);
  endfunction

  function automatic logic [7:0] ilv_sym(input int t, input int i, input int j);
    int s;
    s = t - (t % i) * j * i;
    return (s < 0) ? 8'hA5 : src_sym(s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // check the output of the previous cycle, then drive the next one
  task automatic step(input bit v, input bit fs, input bit acc, input int t,
                      input int i, input int j, input string tag);
    int f;
    @(negedge clk);
    if (p_acc) begin
      f = p_j * p_i * (p_i - 1);
      chk(valid_o == 1'b1, {"R3 ", p_tag}, int'(valid_o), 1);
      chk(filled_o == (p_t >= f), {"R6 ", p_tag}, int'(filled_o), int'(p_t >= f));
      if (p_t % p_i == p_i - 1)
        chk(data_o == p_din, {"R5 ", p_tag}, int'(data_o), int'(p_din));
      if (p_t >= f)
        chk(data_o == src_sym(p_t - f), {"R4 ", p_tag}, int'(data_o), int'(src_sym(p_t - f)));
    end else begin
      chk(valid_o == 1'b0, {"R3 R7 ", p_tag}, int'(valid_o), 0);
    end
    valid_i       = v;
    frame_start_i = fs;
    data_i        = v ? ilv_sym(t, i, j) : 8'h00;
    depth_i       = I_W'(i);
    step_i        = J_W'(j);
    p_acc = acc; p_t = t; p_i = i; p_j = j; p_din = data_i; p_tag = tag;
  endtask

  task automatic run_stream(input int i, input int j, input int n, input bit gaps,
                            input int fs_per, input string tag);
    for (int t = 0; t < n; t++) begin
      if (gaps && (t % 7 == 3)) step(1'b0, 1'b0, 1'b0, p_t, p_i, p_j, "R7 idle");
      step(1'b1, (t == 0) || (fs_per != 0 && t % fs_per == 0), 1'b1, t, i, j, tag);
    end
  endtask

  initial begin
    #(CLK_P * 3);
    chk(valid_o == 1'b0 && filled_o == 1'b0, "R1 in reset", int'({valid_o, filled_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && filled_o == 1'b0, "R1 after reset", int'({valid_o, filled_o}), 0);
    // R2: symbols before any frame start are dropped
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, k, 4, 2, "R2 unprimed");
    run_stream(2, 1, 40, 1'b0, 0, "R9 first");
    run_stream(3, 2, 100, 1'b1, 0, "R9 new mode");
    run_stream(4, 3, 198, 1'b0, 8, "R8 aligned frame starts");
    run_stream(4, 3, 200, 1'b1, 12, "R9 misaligned restart");
    run_stream(8, 2, 300, 1'b1, 0, "R9 mode change");
    run_stream(12, 17, 2600, 1'b1, 204, "R4 R8 depth 12");
    run_stream(5, 1, 60, 1'b0, 0, "R10 small");
    step(1'b0, 1'b0, 1'b0, 0, 5, 1, "tail");
    step(1'b0, 1'b0, 1'b0, 0, 5, 1, "tail");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule